// File: doc/BRIEF.md
# Four-State Address Pin Decoder

This block works out how each of two address-select pins is wired. A pin can be tied to ground, tied to supply, joined to the serial data line or joined to the serial clock line. While a bus transmission is in progress, the block compares every sampled pin level against the sampled data and clock levels. It does this for every transmission on the bus, whatever device the transmission addresses. When a transmission that carried at least one whole byte ends with a STOP, the block commits a new wiring class for each pin. Because the class is refreshed on every transmission, a board can change a pin's wiring at run time without a power cycle.

Both classes feed three outputs: a 7-bit slave address, a per-port pullup-enable vector and the default output byte used at power-up. Between reset and the first committed transmission the block cannot yet tell bus-tied pins apart. Since the bus idles high, in that window it classifies each pin by its live level alone.

Top module: `apd_addr_decoder`

## Requirements
- R1: The slave address is {3'b110, code of pin B (2 bits), code of pin A (2 bits)}, so 16 addresses can be selected.
- R2: Pin A code (address bits 1:0): ground 00, supply 01, clock line 10, data line 11.
- R3: Pin B code (address bits 3:2): clock line 00, data line 01, ground 10, supply 11.
- R4: Within a transmission a pin is classed as data line if it fell in the same cycle as the data line at START and matched the data line on every sampled cycle through STOP. Otherwise it is classed as clock line if it matched the clock line on every such cycle. Otherwise it takes its own level at STOP: high gives supply, low gives ground.
- R5: Each qualifying transmission re-classifies both pins, whatever address byte it carries.
- R6: From reset until the first committed STOP, each pin is classed by its live level: high gives supply, low gives ground.
- R7: A class is committed only at a STOP that comes at least 8 rising clock-line edges after the last START. A shorter transfer leaves the address and both vectors unchanged.
- R8: Pullup-enable bits 3:2 are 1 when pin A is not classed ground, and bits 5:4 are 1 when pin B is not classed ground. Bits 7:6 and 1:0 are always 0.
- R9: Default output bits 3:0 are all 1 when pin A is not classed ground, and bits 7:4 are all 1 when pin B is not classed ground. Otherwise those bits are 0.
- R10: The asynchronous active-low reset clears all committed state, which puts the block back into the live-level behaviour of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Synchronized serial data line level |
| scl_i | input | 1 | Synchronized serial clock line level |
| pin_a_i | input | 1 | Synchronized level of address pin A |
| pin_b_i | input | 1 | Synchronized level of address pin B |
| slave_addr_o | output | 7 | Decoded 7-bit slave address |
| pull_en_o | output | 8 | Per-port pullup enables |
| dflt_o | output | 8 | Power-up default output levels |

## Verification
A STOP commit and a change in a data-tied pin's own level always happen in the same cycle, because that pin rises together with the data line at STOP. The commit decision therefore has to count the equality in that final cycle rather than the pin's earlier static value. Every wiring combination that includes a data-tied pin triggers this case. The outcome is judged by whether the address shows the data-line code and not the supply code. A second overlap occurs at the end of a transfer that is too short: the STOP arrives in the same cycle in which the transfer is abandoned. The bench triggers this with a four-bit transfer and checks that the address does not change.

// File: rtl/apd_pkg.sv
package apd_pkg;
  typedef enum logic [1:0] {
    PIN_GND = 2'd0,
    PIN_VDD = 2'd1,
    PIN_SCL = 2'd2,
    PIN_SDA = 2'd3
  } pin_wire_e;

  localparam int ADDR_W   = 7;
  localparam int PORT_W   = 8;
  localparam int NUM_PINS = 2;
  localparam logic [2:0] ADDR_PREFIX = 3'b110;
endpackage

// File: rtl/apd_bus_watch.sv
module apd_bus_watch #(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_i,
  input  logic scl_i,
  output logic start_o,
  output logic stop_o,
  output logic active_o,
  output logic full_o
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BYTE_BITS);

  logic             sda_q, scl_q, active_q;
  logic             active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             scl_rise;

  always_comb begin
    start_o  = scl_i & scl_q & sda_q & ~sda_i;
    stop_o   = scl_i & scl_q & ~sda_q & sda_i;
    scl_rise = scl_i & ~scl_q;
  end

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (start_o) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (stop_o) begin
      active_d = 1'b0;
    end else if (active_q && scl_rise && (cnt_q < CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q    <= 1'b1;
      scl_q    <= 1'b1;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sda_q    <= sda_i;
      scl_q    <= scl_i;
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;
  assign full_o   = active_q && (cnt_q == CNT_MAX);

  p_cnt_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  p_active_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(start_o));
  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && !start_o) |=> !active_q);
endmodule

// File: rtl/apd_pin_track.sv
module apd_pin_track
  import apd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  logic      sda_i,
  input  logic      scl_i,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      active_i,
  input  logic      full_i,
  output pin_wire_e cls_o,
  output logic      resolved_o
);
  logic      pin_q;
  logic      sda_ok_q, sda_ok_d;
  logic      scl_ok_q, scl_ok_d;
  pin_wire_e cls_q, cls_d;
  logic      res_q, res_d;
  logic      sda_eq, scl_eq, commit;
  pin_wire_e level_cls;

  always_comb begin
    sda_eq    = (pin_i == sda_i);
    scl_eq    = (pin_i == scl_i);
    commit    = stop_i & full_i;
    level_cls = pin_i ? PIN_VDD : PIN_GND;
  end

  always_comb begin
    sda_ok_d = sda_ok_q;
    scl_ok_d = scl_ok_q;
    cls_d    = cls_q;
    res_d    = res_q;
    if (start_i) begin
      sda_ok_d = sda_eq & pin_q;
      scl_ok_d = scl_eq;
    end else if (active_i) begin
      sda_ok_d = sda_ok_q & sda_eq;
      scl_ok_d = scl_ok_q & scl_eq;
    end
    if (commit) begin
      res_d = 1'b1;
      if (sda_ok_q && sda_eq)      cls_d = PIN_SDA;
      else if (scl_ok_q && scl_eq) cls_d = PIN_SCL;
      else                         cls_d = level_cls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= 1'b1;
      sda_ok_q <= 1'b0;
      scl_ok_q <= 1'b0;
      cls_q    <= PIN_VDD;
      res_q    <= 1'b0;
    end else begin
      pin_q    <= pin_i;
      sda_ok_q <= sda_ok_d;
      scl_ok_q <= scl_ok_d;
      cls_q    <= cls_d;
      res_q    <= res_d;
    end
  end

  assign cls_o      = res_q ? cls_q : level_cls;
  assign resolved_o = res_q;

  p_hold_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_i && full_i) |=> $stable(cls_q));
  p_resolve_at_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_q) |-> $past(stop_i));
  p_sda_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_ok_q) |-> $past(start_i));
endmodule

// File: rtl/apd_addr_map.sv
module apd_addr_map
  import apd_pkg::*;
(
  input  pin_wire_e          cls_a_i,
  input  pin_wire_e          cls_b_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [PORT_W-1:0]  pull_o,
  output logic [PORT_W-1:0]  dflt_o
);
  localparam int HALF = PORT_W / 2;

  function automatic logic [1:0] code_a(pin_wire_e c);
    case (c)
      PIN_GND: code_a = 2'b00;
      PIN_VDD: code_a = 2'b01;
      PIN_SCL: code_a = 2'b10;
      default: code_a = 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] code_b(pin_wire_e c);
    case (c)
      PIN_SCL: code_b = 2'b00;
      PIN_SDA: code_b = 2'b01;
      PIN_GND: code_b = 2'b10;
      default: code_b = 2'b11;
    endcase
  endfunction

  logic hi_a, hi_b;

  always_comb begin
    hi_a   = (cls_a_i != PIN_GND);
    hi_b   = (cls_b_i != PIN_GND);
    addr_o = {ADDR_PREFIX, code_b(cls_b_i), code_a(cls_a_i)};
    pull_o = '0;
    pull_o[3:2] = {2{hi_a}};
    pull_o[5:4] = {2{hi_b}};
    dflt_o = {{HALF{hi_b}}, {HALF{hi_a}}};
  end
endmodule

// File: rtl/apd_addr_decoder.sv
module apd_addr_decoder
  import apd_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  output logic [ADDR_W-1:0] slave_addr_o,
  output logic [PORT_W-1:0] pull_en_o,
  output logic [PORT_W-1:0] dflt_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic start, stop, active, full;

  apd_bus_watch #(.BYTE_BITS(BYTE_BITS)) u_watch (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sda_i    (sda_i),
    .scl_i    (scl_i),
    .start_o  (start),
    .stop_o   (stop),
    .active_o (active),
    .full_o   (full)
  );

  logic [NUM_PINS-1:0] pins;
  logic [NUM_PINS-1:0] resolved;
  pin_wire_e           cls [NUM_PINS];

  assign pins = {pin_b_i, pin_a_i};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    apd_pin_track u_track (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .pin_i      (pins[g]),
      .sda_i      (sda_i),
      .scl_i      (scl_i),
      .start_i    (start),
      .stop_i     (stop),
      .active_i   (active),
      .full_i     (full),
      .cls_o      (cls[g]),
      .resolved_o (resolved[g])
    );
  end

  apd_addr_map u_map (
    .cls_a_i (cls[0]),
    .cls_b_i (cls[1]),
    .addr_o  (slave_addr_o),
    .pull_o  (pull_en_o),
    .dflt_o  (dflt_o)
  );

  p_pins_resolve_together_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    resolved[0] == resolved[1]);
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (resolved[0] && !(stop && full) && $stable(pins)) |=> $stable(slave_addr_o));
endmodule

// File: tb/apd_addr_decoder_tb.sv
module apd_addr_decoder_tb;
  localparam int W_GND = 0, W_VDD = 1, W_SCL = 2, W_SDA = 3;

  // entry: {wiring B, wiring A, expected low address nibble}
  localparam logic [7:0] VEC [16] = '{
    8'b00_00_1000, 8'b00_01_1001, 8'b00_10_1010, 8'b00_11_1011,
    8'b01_00_1100, 8'b01_01_1101, 8'b01_10_1110, 8'b01_11_1111,
    8'b10_00_0000, 8'b10_01_0001, 8'b10_10_0010, 8'b10_11_0011,
    8'b11_00_0100, 8'b11_01_0101, 8'b11_10_0110, 8'b11_11_0111
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda = 1'b1, scl = 1'b1;
  logic [1:0] wa = 2'd1, wb = 2'd1;
  logic pin_a, pin_b;
  logic [6:0] addr;
  logic [7:0] pull, dflt;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  function automatic logic wire_lvl(logic [1:0] w, logic d, logic c);
    case (w)
      2'd0: wire_lvl = 1'b0;
      2'd1: wire_lvl = 1'b1;
      2'd2: wire_lvl = c;
      default: wire_lvl = d;
    endcase
  endfunction

  assign pin_a = wire_lvl(wa, sda, scl);
  assign pin_b = wire_lvl(wb, sda, scl);

  apd_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .sda_i(sda), .scl_i(scl),
    .pin_a_i(pin_a), .pin_b_i(pin_b),
    .slave_addr_o(addr), .pull_en_o(pull), .dflt_o(dflt)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [3:0] nib, logic hi_a, logic hi_b);
    chk({tag, " addr R1 R2 R3"}, {1'b0, addr}, {1'b0, 3'b110, nib});
    chk({tag, " pull R8"}, pull, {2'b00, hi_b, hi_b, hi_a, hi_a, 2'b00});
    chk({tag, " dflt R9"}, dflt, {{4{hi_b}}, {4{hi_a}}});
  endtask

  task automatic xfer(logic [7:0] data, int nbits);
    sda = 1'b1; scl = 1'b1; step(2);
    sda = 1'b0; step(2);
    scl = 1'b0; step(2);
    for (int i = 0; i < nbits; i++) begin
      sda = (i < 8) ? data[7-i] : 1'b0;
      step(2);
      scl = 1'b1; step(2);
      scl = 1'b0; step(2);
    end
    sda = 1'b0; step(2);
    scl = 1'b1; step(2);
    sda = 1'b1; step(3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(2);
    rst_n = 1'b1; step(4);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10 R6: reset with bus-tied pins -> seen as supply
    wa = 2'(W_SDA); wb = 2'(W_SCL);
    do_reset();
    chk_all("R10 R6 reset", 4'b1101, 1'b1, 1'b1);
    // R6: unresolved follows live level
    wb = 2'(W_GND); step(2);
    chk_all("R6 live", 4'b1001, 1'b1, 1'b0);

    // R4 R5: all 16 wiring combinations, varied address bytes
    for (int i = 0; i < 16; i++) begin
      wb = VEC[i][7:6]; wa = VEC[i][5:4];
      xfer(8'(8'h3C ^ (i * 37)), 9);
      chk_all("R4 R5 table", VEC[i][3:0], VEC[i][5:4] != 2'd0, VEC[i][7:6] != 2'd0);
    end

    // R7: short transfer leaves address unchanged (last entry SDA/SDA)
    wa = 2'(W_GND); wb = 2'(W_GND);
    xfer(8'hA5, 4);
    chk_all("R7 short", 4'b0111, 1'b1, 1'b1);
    // R7: exactly 8 bits qualifies
    xfer(8'hA5, 8);
    chk_all("R7 eight", 4'b1000, 1'b0, 1'b0);

    // R4: data-tied pin vs clock-tied pin on the other
    wa = 2'(W_SCL); wb = 2'(W_SDA);
    xfer(8'h00, 9);
    chk_all("R4 mixed", 4'b0110, 1'b1, 1'b1);

    // R10: reset clears committed class, GND/VDD live
    wa = 2'(W_VDD); wb = 2'(W_GND);
    do_reset();
    chk_all("R10 clear", 4'b1001, 1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule